// File: doc/BRIEF.md
# Exposed-control shared-bus datapath

This block is a datapath with no controller of its own. Each clock cycle an outside controller presents a flat set of control bits, and those bits alone decide which storage drives which bus, what each functional unit computes, and where the result is written. The block holds two working registers (`r1`, `r2`) and a three-word scratch memory. Three shared buses connect them to two functional units: an adder/subtractor and a multiplier that can also do XOR.

The left operand bus carries `r1`. The right operand bus carries either `r2` or the addressed memory word. The result bus carries the output of one of the two functional units. That result can be loaded into `r1` or written into memory at the same cycle's address. `r2` is loaded from a dedicated data input, which is how operands enter the block. Each bus is built as a one-hot guarded OR of its sources, with no tristate. A bus whose drivers are all disabled reads as zero. Enabling two drivers on one bus in the same cycle is a controller error, and the bound checker reports it.

All three buses and both registers are brought out so that the controller, or a bench, can watch every transfer. A complete register transfer such as `r1 = r1 * M(0)` or `r1 = r1 - r2` takes exactly one cycle.

Top module: `dpx_datapath`

## Requirements
- R1: After reset, `r1_q` and `r2_q` are zero, and every memory word reads back as zero.
- R2: `bus1` equals `r1_q` while `c_r1_to_b1` is 1, and zero otherwise.
- R3: `bus2` equals `r2_q` while `c_r2_to_b2` is 1. It equals the memory word at `c_mem_addr` while `c_mem_to_b2` is 1. It is zero when neither is set. The read is combinational in the same cycle.
- R4: `bus3` equals the adder/subtractor output while `c_fu1_to_b3` is 1, and the multiply/XOR output while `c_fu2_to_b3` is 1. It is zero when neither is set.
- R5: The adder/subtractor computes `bus1 + bus2` when `c_fu1_sub` is 0 and `bus1 - bus2` when it is 1, modulo 2^W.
- R6: The second unit computes the low W bits of `bus1 * bus2` when `c_fu2_alt` is 0 and `bus1 ^ bus2` when it is 1.
- R7: On a rising edge with `ld_r1` = 1, `r1_q` takes `bus3`. With `ld_r2` = 1, `r2_q` takes `r2_din`. A register whose load bit is 0 keeps its value.
- R8: On a rising edge with `c_mem_wr` = 1, `bus3` is stored at `c_mem_addr` when the address is 0, 1 or 2. An address of 3 writes nothing, and a read at address 3 gives zero.
- R9: At most one of `c_r2_to_b2` and `c_mem_to_b2`, and at most one of `c_fu1_to_b3` and `c_fu2_to_b3`, is 1 in any cycle.
- R10: The control word {drive r1, drive memory, route FU2, FU2 multiply, address 0, load r1} performs `r1 = r1 * M(0)` in one cycle. The word {drive r1, drive r2, route FU1, subtract, load r1} performs `r1 = r1 - r2` in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_r1_to_b1 | input | 1 | r1 drives bus1 |
| c_r2_to_b2 | input | 1 | r2 drives bus2 |
| c_mem_to_b2 | input | 1 | Addressed memory word drives bus2 |
| c_fu1_to_b3 | input | 1 | Adder/subtractor drives bus3 |
| c_fu2_to_b3 | input | 1 | Multiply/XOR unit drives bus3 |
| c_fu1_sub | input | 1 | 0 add, 1 subtract |
| c_fu2_alt | input | 1 | 0 multiply (low half), 1 XOR |
| c_mem_addr | input | AW (2) | Memory word address |
| c_mem_wr | input | 1 | 1 writes bus3 into memory at the edge |
| ld_r1 | input | 1 | Load r1 from bus3 |
| ld_r2 | input | 1 | Load r2 from r2_din |
| r2_din | input | W (16) | Data entering r2 |
| r1_q | output | W (16) | Register r1 |
| r2_q | output | W (16) | Register r2 |
| bus1 | output | W (16) | Left operand bus |
| bus2 | output | W (16) | Right operand bus |
| bus3 | output | W (16) | Result bus |

## Verification
Every bus is visible at the ports, so a wrong driver select or a wrong functional-unit operation appears on `bus2` or `bus3` in the same cycle the control word is applied, before any register edge. A corrupted register shows on `r1_q` or `r2_q` one edge after the faulty load. A bad memory word stays hidden until a later word routes that address onto `bus2`. For that reason the bench reads every address back, including the unimplemented one, after each write pattern.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  // adder/subtractor operation select
  typedef enum logic {
    ADDSUB_ADD = 1'b0,
    ADDSUB_SUB = 1'b1
  } addsub_op_e;

  // second functional unit operation select
  typedef enum logic {
    MULX_MUL = 1'b0,
    MULX_XOR = 1'b1
  } mulx_op_e;
endpackage

// File: rtl/dpx_onehot_bus.sv
module dpx_onehot_bus #(
  parameter int W = 16,
  parameter int N = 2
) (
  input  logic [N-1:0]        en,
  input  logic [N-1:0][W-1:0] src,
  output logic [W-1:0]        bus
);
  // guarded OR: each source contributes only when its enable is set
  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) begin
      bus = bus | (src[i] & {W{en[i]}});
    end
  end
endmodule

// File: rtl/dpx_fu_addsub.sv
module dpx_fu_addsub
  import dpx_pkg::*;
#(
  parameter int W = 16
) (
  input  addsub_op_e   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    if (op == ADDSUB_SUB) y = a - b;
    else                  y = a + b;
  end
endmodule

// File: rtl/dpx_fu_mulx.sv
module dpx_fu_mulx
  import dpx_pkg::*;
#(
  parameter int W = 16
) (
  input  mulx_op_e     op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [2*W-1:0] prod;

  assign prod = a * b;

  always_comb begin
    if (op == MULX_XOR) y = a ^ b;
    else                y = prod[W-1:0];
  end
endmodule

// File: rtl/dpx_store.sv
module dpx_store #(
  parameter int W     = 16,
  parameter int WORDS = 3,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          mem[g] <= '0;
        else if (we && (addr == AW'(g)))     mem[g] <= wdata;
      end
    end
  endgenerate

  // unimplemented addresses read as zero
  always_comb begin
    rdata = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (addr == AW'(i)) rdata = mem[i];
    end
  end
endmodule

// File: rtl/dpx_datapath.sv
module dpx_datapath
  import dpx_pkg::*;
#(
  parameter int W         = 16,
  parameter int MEM_WORDS = 3,
  parameter int AW        = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          c_r1_to_b1,
  input  logic          c_r2_to_b2,
  input  logic          c_mem_to_b2,
  input  logic          c_fu1_to_b3,
  input  logic          c_fu2_to_b3,
  input  logic          c_fu1_sub,
  input  logic          c_fu2_alt,
  input  logic [AW-1:0] c_mem_addr,
  input  logic          c_mem_wr,
  input  logic          ld_r1,
  input  logic          ld_r2,
  input  logic [W-1:0]  r2_din,
  output logic [W-1:0]  r1_q,
  output logic [W-1:0]  r2_q,
  output logic [W-1:0]  bus1,
  output logic [W-1:0]  bus2,
  output logic [W-1:0]  bus3
);
  localparam int B2_SRCS = 2;
  localparam int B3_SRCS = 2;

  logic [W-1:0] mem_rd;
  logic [W-1:0] fu1_y;
  logic [W-1:0] fu2_y;

  // bus1: single source
  dpx_onehot_bus #(.W(W), .N(1)) u_bus1 (
    .en  (c_r1_to_b1),
    .src (r1_q),
    .bus (bus1)
  );

  // bus2: r2 or memory
  dpx_onehot_bus #(.W(W), .N(B2_SRCS)) u_bus2 (
    .en  ({c_mem_to_b2, c_r2_to_b2}),
    .src ({mem_rd, r2_q}),
    .bus (bus2)
  );

  // bus3: FU2 or FU1
  dpx_onehot_bus #(.W(W), .N(B3_SRCS)) u_bus3 (
    .en  ({c_fu2_to_b3, c_fu1_to_b3}),
    .src ({fu2_y, fu1_y}),
    .bus (bus3)
  );

  dpx_fu_addsub #(.W(W)) u_fu1 (
    .op (addsub_op_e'(c_fu1_sub)),
    .a  (bus1),
    .b  (bus2),
    .y  (fu1_y)
  );

  dpx_fu_mulx #(.W(W)) u_fu2 (
    .op (mulx_op_e'(c_fu2_alt)),
    .a  (bus1),
    .b  (bus2),
    .y  (fu2_y)
  );

  dpx_store #(.W(W), .WORDS(MEM_WORDS), .AW(AW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (c_mem_addr),
    .we    (c_mem_wr),
    .wdata (bus3),
    .rdata (mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= '0;
      r2_q <= '0;
    end else begin
      if (ld_r1) r1_q <= bus3;
      if (ld_r2) r2_q <= r2_din;
    end
  end
endmodule

// File: rtl/dpx_datapath_chk.sv
module dpx_datapath_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         c_r1_to_b1,
  input logic         c_r2_to_b2,
  input logic         c_mem_to_b2,
  input logic         c_fu1_to_b3,
  input logic         c_fu2_to_b3,
  input logic         ld_r1,
  input logic         ld_r2,
  input logic [W-1:0] r2_din,
  input logic [W-1:0] r1_q,
  input logic [W-1:0] r2_q,
  input logic [W-1:0] bus1,
  input logic [W-1:0] bus3
);
  // R9
  bus2_one_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_r2_to_b2 && c_mem_to_b2));

  // R9
  bus3_one_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_fu1_to_b3 && c_fu2_to_b3));

  // R2
  bus1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_r1_to_b1 |-> (bus1 == '0));

  // R4
  bus3_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_fu1_to_b3 || c_fu2_to_b3) |-> (bus3 == '0));

  // R7
  r1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_r1 |=> (r1_q == $past(bus3)));

  // R7
  r1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_r1 |=> $stable(r1_q));

  // R7
  r2_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_r2 |=> (r2_q == $past(r2_din)));

  // R7
  r2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_r2 |=> $stable(r2_q));
endmodule

bind dpx_datapath dpx_datapath_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .c_r1_to_b1  (c_r1_to_b1),
  .c_r2_to_b2  (c_r2_to_b2),
  .c_mem_to_b2 (c_mem_to_b2),
  .c_fu1_to_b3 (c_fu1_to_b3),
  .c_fu2_to_b3 (c_fu2_to_b3),
  .ld_r1       (ld_r1),
  .ld_r2       (ld_r2),
  .r2_din      (r2_din),
  .r1_q        (r1_q),
  .r2_q        (r2_q),
  .bus1        (bus1),
  .bus3        (bus3)
);

// File: tb/dpx_datapath_tb.sv
module dpx_datapath_tb;
  localparam int W = 16;

  typedef struct packed {
    logic       b1;
    logic       r2b2;
    logic       mb2;
    logic       f1b3;
    logic       f2b3;
    logic       sub;
    logic       alt;
    logic [1:0] addr;
    logic       wr;
    logic       ldr1;
  } cw_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         c_r1_to_b1 = 0, c_r2_to_b2 = 0, c_mem_to_b2 = 0;
  logic         c_fu1_to_b3 = 0, c_fu2_to_b3 = 0, c_fu1_sub = 0, c_fu2_alt = 0;
  logic [1:0]   c_mem_addr = '0;
  logic         c_mem_wr = 0, ld_r1 = 0, ld_r2 = 0;
  logic [W-1:0] r2_din = '0;
  logic [W-1:0] r1_q, r2_q, bus1, bus2, bus3;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dpx_datapath u_dut (
    .clk(clk), .rst_n(rst_n),
    .c_r1_to_b1(c_r1_to_b1), .c_r2_to_b2(c_r2_to_b2), .c_mem_to_b2(c_mem_to_b2),
    .c_fu1_to_b3(c_fu1_to_b3), .c_fu2_to_b3(c_fu2_to_b3),
    .c_fu1_sub(c_fu1_sub), .c_fu2_alt(c_fu2_alt),
    .c_mem_addr(c_mem_addr), .c_mem_wr(c_mem_wr),
    .ld_r1(ld_r1), .ld_r2(ld_r2), .r2_din(r2_din),
    .r1_q(r1_q), .r2_q(r2_q), .bus1(bus1), .bus2(bus2), .bus3(bus3)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  function automatic cw_t idle_w();
    return '0;
  endfunction

  // apply a control word at the falling edge; buses settle right after
  task automatic drive(input cw_t w);
    @(negedge clk);
    c_r1_to_b1 = w.b1;  c_r2_to_b2 = w.r2b2; c_mem_to_b2 = w.mb2;
    c_fu1_to_b3 = w.f1b3; c_fu2_to_b3 = w.f2b3;
    c_fu1_sub = w.sub;  c_fu2_alt = w.alt;
    c_mem_addr = w.addr; c_mem_wr = w.wr; ld_r1 = w.ldr1;
    ld_r2 = 1'b0;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_r2(input logic [W-1:0] v);
    drive(idle_w());
    ld_r2 = 1'b1; r2_din = v;
    tick();
    ld_r2 = 1'b0;
  endtask

  // r1 = 0 + r2 (bus1 undriven reads zero)
  task automatic set_r1(input logic [W-1:0] v);
    cw_t w;
    set_r2(v);
    w = idle_w(); w.r2b2 = 1; w.f1b3 = 1; w.ldr1 = 1;
    drive(w);
    tick();
  endtask

  task automatic mem_write(input logic [1:0] a, input logic [W-1:0] v);
    cw_t w;
    set_r2(v);
    w = idle_w(); w.r2b2 = 1; w.f1b3 = 1; w.addr = a; w.wr = 1;
    drive(w);
    tick();
  endtask

  task automatic mem_read_chk(input logic [1:0] a, input logic [W-1:0] exp, input string req);
    cw_t w;
    w = idle_w(); w.mb2 = 1; w.addr = a;
    drive(w);
    check(req, bus2, exp);
  endtask

  task automatic t_reset();
    check("R1 r1 after reset", r1_q, '0);
    check("R1 r2 after reset", r2_q, '0);
    for (int a = 0; a < 3; a++) mem_read_chk(2'(a), '0, "R1 memory after reset");
  endtask

  task automatic t_bus_select();
    cw_t w;
    set_r1(16'h1357);
    set_r2(16'h2468);
    w = idle_w(); w.b1 = 1;
    drive(w);
    check("R2 bus1 driven", bus1, 16'h1357);
    check("R4 bus3 no driver", bus3, '0);
    w = idle_w();
    drive(w);
    check("R2 bus1 undriven", bus1, '0);
    check("R3 bus2 undriven", bus2, '0);
    w = idle_w(); w.r2b2 = 1;
    drive(w);
    check("R3 bus2 from r2", bus2, 16'h2468);
  endtask

  task automatic t_addsub();
    cw_t w;
    set_r1(16'h0005);
    set_r2(16'h0007);
    w = idle_w(); w.b1 = 1; w.r2b2 = 1; w.f1b3 = 1;
    drive(w);
    check("R5 add", bus3, 16'h000C);
    w.sub = 1;
    drive(w);
    check("R5 subtract wraps", bus3, 16'hFFFE);
    set_r1(16'hFFFF);
    set_r2(16'h0003);
    w = idle_w(); w.b1 = 1; w.r2b2 = 1; w.f1b3 = 1;
    drive(w);
    check("R5 add wraps", bus3, 16'h0002);
  endtask

  task automatic t_mulx();
    cw_t w;
    set_r1(16'h0300);
    set_r2(16'h0101);
    w = idle_w(); w.b1 = 1; w.r2b2 = 1; w.f2b3 = 1;
    drive(w);
    check("R6 multiply low half", bus3, 16'h0300);
    w.alt = 1;
    drive(w);
    check("R6 xor", bus3, 16'h0201);
    w.alt = 0; w.f2b3 = 0; w.f1b3 = 1;
    drive(w);
    check("R4 bus3 from FU1", bus3, 16'h0401);
  endtask

  task automatic t_hold_load();
    cw_t w;
    set_r1(16'h00AA);
    set_r2(16'h0011);
    w = idle_w(); w.b1 = 1; w.r2b2 = 1; w.f1b3 = 1;
    drive(w);
    tick();
    check("R7 r1 holds without load", r1_q, 16'h00AA);
    w.ldr1 = 1;
    drive(w);
    tick();
    check("R7 r1 loads bus3", r1_q, 16'h00BB);
    check("R7 r2 holds without load", r2_q, 16'h0011);
  endtask

  task automatic t_memory();
    mem_write(2'd1, 16'h1234);
    mem_write(2'd2, 16'hBEEF);
    mem_write(2'd0, 16'h0007);
    mem_read_chk(2'd1, 16'h1234, "R8 read word 1");
    mem_read_chk(2'd2, 16'hBEEF, "R8 read word 2");
    mem_write(2'd3, 16'h0055);
    mem_read_chk(2'd3, 16'h0000, "R8 address 3 reads zero");
    mem_read_chk(2'd0, 16'h0007, "R8 word 0 untouched by address 3 write");
    mem_read_chk(2'd1, 16'h1234, "R8 word 1 untouched by address 3 write");
    mem_read_chk(2'd2, 16'hBEEF, "R8 word 2 untouched by address 3 write");
  endtask

  // replay of stored control words, one per cycle
  task automatic t_replay();
    cw_t prog [2];
    logic [W-1:0] exp [2];
    set_r1(16'h0006);
    set_r2(16'h0004);
    prog[0] = idle_w(); prog[0].b1 = 1; prog[0].mb2 = 1; prog[0].f2b3 = 1;
    prog[0].addr = 2'd0; prog[0].ldr1 = 1;
    prog[1] = idle_w(); prog[1].b1 = 1; prog[1].r2b2 = 1; prog[1].f1b3 = 1;
    prog[1].sub = 1; prog[1].ldr1 = 1;
    exp[0] = 16'h002A;
    exp[1] = 16'h0026;
    for (int k = 0; k < 2; k++) begin
      drive(prog[k]);
      tick();
      check("R10 one-cycle register transfer", r1_q, exp[k]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_bus_select();
    t_addsub();
    t_mulx();
    t_hold_load();
    t_memory();
    t_replay();
    drive(idle_w());
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule